// File: doc/BRIEF.md
# Per-Core Power Zone Sequencer

This block walks one CPU power zone at a time through a fixed list of manual control steps, either to bring the zone up or to take it down. For every zone it drives six control lines: clock enable, reset release, memory power, an auxiliary power enable, isolation and manual mode. It watches two status lines per zone, memory power good and power gate good, and it waits on them between steps. A third status line per zone reports that the zone sits in reset, which means the zone is off.

Software, or a higher-level controller, issues commands through a valid/ready port. A command carries a direction, a core index and a boot address. The port takes a command only while no sequence runs and no timeout error is latched. While `cmd_ready` is low the issuer must hold `cmd_valid` and the command fields steady. A power-up on a zone that is already on skips the power steps and goes straight to the boot step. The boot step writes zero to the zone's upper boot word, loads its lower boot word with the address, and then clears that core's halt bit. A power-down ends by setting the core's halt bit. Core 0 may never be powered down.

Top module: `pzone_seq`

## Requirements
- R1: After reset all zone control outputs are 0, every boot word is all ones, halt bits are set for every core except core 0, `cmd_ready` is 1, and `busy`, `done`, `fail` and `tmo_err` are 0.
- R2: `cmd_ready` is high only while no sequence runs and `tmo_err` is clear; a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and an accepted command that is not refused shows `busy` high from the next cycle until the sequence ends.
- R3: A power-up (`cmd_up`=1) on a zone whose reset status is 1 changes one output per cycle in this order: isolation on, manual on, auxiliary power on, memory power on, wait for memory good = 1, clock enable on, wait for power gate good = 1, isolation off, reset released.
- R4: A power-down (`cmd_up`=0) changes one output per cycle in this order: manual on, reset held (reset release cleared), clock enable off, isolation on, memory power off, wait for memory good = 0, auxiliary power off, wait for power gate good = 0, halt bit set.
- R5: A wait step holds the sequence while its status line differs from the expected level, and the next step's output change appears on the second clock edge after the status reaches that level.
- R6: If a wait step sees its status at the wrong level for TMO_MS × CYC_PER_MS consecutive cycles, the sequence stops with outputs left as they are, `tmo_err` sets, `busy` drops and `done` does not pulse.
- R7: `tmo_err` stays set, and `cmd_ready` stays low, until `err_clr` is high on a clock edge; a timeout on the same edge wins.
- R8: A power-down command for core 0 is accepted, then `fail` pulses for one cycle, `busy` stays low and no output changes.
- R9: A power-up on a zone whose reset status is 0 skips the power steps, so `done` appears three cycles after acceptance.
- R10: The boot step writes zero to the core's upper boot word, then the address to its lower boot word, then clears only that core's halt bit, each in its own cycle; `done` pulses for one cycle at the end of a power-up.
- R11: A completed power-down leaves the core's halt bit set, with other halt bits unchanged, and pulses `done` for one cycle.
- R12: Only the commanded core's outputs change during a sequence; at most one zone's control lines change in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_up | input | 1 | 1 = power up and boot, 0 = power down |
| cmd_core | input | CW = clog2(N) | Target core index |
| cmd_addr | input | AW | Boot address for a power-up |
| err_clr | input | 1 | Clears the latched timeout error |
| zs_mem_ok | input | N | Memory power good, one per zone |
| zs_pg_ok | input | N | Power gate good, one per zone |
| zs_off | input | N | Zone held in reset (powered off) |
| zc_clk_en | output | N | Clock enable per zone |
| zc_rst_rel | output | N | Reset release per zone (1 = out of reset) |
| zc_mem_pwr | output | N | Memory power enable per zone |
| zc_aux_pwr | output | N | Auxiliary power enable per zone |
| zc_iso | output | N | Isolation per zone |
| zc_manual | output | N | Manual mode per zone |
| halt | output | N | Per-core halt bits |
| vec_hi | output | N*AW | Upper boot words, core i at bits [i*AW +: AW] |
| vec_lo | output | N*AW | Lower boot words, core i at bits [i*AW +: AW] |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| fail | output | 1 | One-cycle pulse when a command is refused |
| tmo_err | output | 1 | Latched timeout error |

## Verification
The bench drives a small plant model that answers the power lines after a few cycles and can freeze a zone's memory status. A behavioural step-list model, compared on every clock, catches any swapped step, merged step or wrong wait level. A sequencer that advanced in the same cycle the status arrived, or that took a step early, would show the clock enable one cycle too soon. A run with memory good frozen low must end with the error latched, no `done` and the port blocked until the clear pulse; a design that kept waiting or let commands through would differ there. A power-down of core 0 must leave every output untouched, and a power-up of a zone that is already on must finish in three cycles. Designs that touched core 0 or reran the power steps would miss both.

// File: rtl/pzs_pkg.sv
package pzs_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_U_ISO, S_U_MAN, S_U_AUX, S_U_MEM, S_U_WMEM, S_U_CLK, S_U_WPG, S_U_UNISO, S_U_REL,
    S_B_HI, S_B_LO, S_B_GO,
    S_D_MAN, S_D_RST, S_D_CLK, S_D_ISO, S_D_MEM, S_D_WMEM, S_D_AUX, S_D_WPG, S_D_HALT
  } pzs_state_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_ISO_SET, OP_ISO_CLR, OP_MAN_SET, OP_AUX_SET, OP_AUX_CLR,
    OP_MEM_SET, OP_MEM_CLR, OP_CLK_SET, OP_CLK_CLR, OP_RST_REL, OP_RST_HOLD,
    OP_VEC_HI, OP_VEC_LO, OP_HALT_CLR, OP_HALT_SET
  } pzs_op_e;

  typedef struct packed {
    logic man;
    logic iso;
    logic aux;
    logic mem;
    logic rst_rel;
    logic clk_en;
  } pzs_zone_t;

endpackage

// File: rtl/pzs_timer.sv
module pzs_timer #(
  parameter int LIM = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic met,
  output logic expire
);
  localparam int CTW = $clog2(LIM + 1);

  logic [CTW-1:0] cnt_q;

  assign expire = run && !met && (cnt_q == CTW'(LIM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || met || expire) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pzs_fsm.sv
module pzs_fsm
  import pzs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_up,
  input  logic [CW-1:0] cmd_core,
  input  logic [AW-1:0] cmd_addr,
  input  logic          err_clr,
  input  logic [N-1:0]  mem_ok,
  input  logic [N-1:0]  pg_ok,
  input  logic [N-1:0]  off_st,
  input  logic          expire,
  output logic          wait_run,
  output logic          wait_met,
  output pzs_op_e       op,
  output logic [CW-1:0] op_core,
  output logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          tmo_err
);
  pzs_state_e    state_q, state_d;
  logic [CW-1:0] core_q;
  logic [AW-1:0] addr_q;
  logic          up_q, done_q, fail_q, err_q;
  logic          accept, refuse, mwait;

  assign cmd_ready = (state_q == S_IDLE) && !err_q;
  assign accept    = cmd_valid && cmd_ready;
  assign refuse    = accept && !cmd_up && (cmd_core == '0);
  assign mwait     = (state_q == S_U_WMEM) || (state_q == S_D_WMEM);
  assign wait_run  = mwait || (state_q == S_U_WPG) || (state_q == S_D_WPG);
  assign wait_met  = mwait ? (mem_ok[core_q] == up_q) : (pg_ok[core_q] == up_q);
  assign op_core   = core_q;
  assign op_addr   = addr_q;
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign tmo_err   = err_q;

  always_comb begin
    state_d = state_q;
    op      = OP_NONE;
    unique case (state_q)
      S_IDLE:    if (accept && !refuse)
                   state_d = !cmd_up ? S_D_MAN : (off_st[cmd_core] ? S_U_ISO : S_B_HI);
      S_U_ISO:   begin op = OP_ISO_SET;  state_d = S_U_MAN;   end
      S_U_MAN:   begin op = OP_MAN_SET;  state_d = S_U_AUX;   end
      S_U_AUX:   begin op = OP_AUX_SET;  state_d = S_U_MEM;   end
      S_U_MEM:   begin op = OP_MEM_SET;  state_d = S_U_WMEM;  end
      S_U_WMEM:  if (wait_met) state_d = S_U_CLK;   else if (expire) state_d = S_IDLE;
      S_U_CLK:   begin op = OP_CLK_SET;  state_d = S_U_WPG;   end
      S_U_WPG:   if (wait_met) state_d = S_U_UNISO; else if (expire) state_d = S_IDLE;
      S_U_UNISO: begin op = OP_ISO_CLR;  state_d = S_U_REL;   end
      S_U_REL:   begin op = OP_RST_REL;  state_d = S_B_HI;    end
      S_B_HI:    begin op = OP_VEC_HI;   state_d = S_B_LO;    end
      S_B_LO:    begin op = OP_VEC_LO;   state_d = S_B_GO;    end
      S_B_GO:    begin op = OP_HALT_CLR; state_d = S_IDLE;    end
      S_D_MAN:   begin op = OP_MAN_SET;  state_d = S_D_RST;   end
      S_D_RST:   begin op = OP_RST_HOLD; state_d = S_D_CLK;   end
      S_D_CLK:   begin op = OP_CLK_CLR;  state_d = S_D_ISO;   end
      S_D_ISO:   begin op = OP_ISO_SET;  state_d = S_D_MEM;   end
      S_D_MEM:   begin op = OP_MEM_CLR;  state_d = S_D_WMEM;  end
      S_D_WMEM:  if (wait_met) state_d = S_D_AUX;   else if (expire) state_d = S_IDLE;
      S_D_AUX:   begin op = OP_AUX_CLR;  state_d = S_D_WPG;   end
      S_D_WPG:   if (wait_met) state_d = S_D_HALT;  else if (expire) state_d = S_IDLE;
      S_D_HALT:  begin op = OP_HALT_SET; state_d = S_IDLE;    end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      core_q  <= '0;
      addr_q  <= '0;
      up_q    <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_B_GO) || (state_q == S_D_HALT);
      fail_q  <= refuse;
      if (expire)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (accept) begin
        core_q <= cmd_core;
        addr_q <= cmd_addr;
        up_q   <= cmd_up;
      end
    end
  end
endmodule

// File: rtl/pzs_zone_bank.sv
module pzs_zone_bank
  import pzs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pzs_op_e       op,
  input  logic [CW-1:0] op_core,
  output logic [N-1:0]  clk_en,
  output logic [N-1:0]  rst_rel,
  output logic [N-1:0]  mem_pwr,
  output logic [N-1:0]  aux_pwr,
  output logic [N-1:0]  iso,
  output logic [N-1:0]  manual
);
  for (genvar i = 0; i < N; i++) begin : g_zone
    pzs_zone_t z_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        z_q <= '0;
      end else if (op_core == CW'(i)) begin
        unique case (op)
          OP_ISO_SET:  z_q.iso     <= 1'b1;
          OP_ISO_CLR:  z_q.iso     <= 1'b0;
          OP_MAN_SET:  z_q.man     <= 1'b1;
          OP_AUX_SET:  z_q.aux     <= 1'b1;
          OP_AUX_CLR:  z_q.aux     <= 1'b0;
          OP_MEM_SET:  z_q.mem     <= 1'b1;
          OP_MEM_CLR:  z_q.mem     <= 1'b0;
          OP_CLK_SET:  z_q.clk_en  <= 1'b1;
          OP_CLK_CLR:  z_q.clk_en  <= 1'b0;
          OP_RST_REL:  z_q.rst_rel <= 1'b1;
          OP_RST_HOLD: z_q.rst_rel <= 1'b0;
          default:     z_q         <= z_q;
        endcase
      end
    end

    assign clk_en[i]  = z_q.clk_en;
    assign rst_rel[i] = z_q.rst_rel;
    assign mem_pwr[i] = z_q.mem;
    assign aux_pwr[i] = z_q.aux;
    assign iso[i]     = z_q.iso;
    assign manual[i]  = z_q.man;
  end
endmodule

// File: rtl/pzs_boot_bank.sv
module pzs_boot_bank
  import pzs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pzs_op_e         op,
  input  logic [CW-1:0]   op_core,
  input  logic [AW-1:0]   op_addr,
  output logic [N-1:0]    halt,
  output logic [N*AW-1:0] vec_hi,
  output logic [N*AW-1:0] vec_lo
);
  for (genvar i = 0; i < N; i++) begin : g_core
    logic          halt_q;
    logic [AW-1:0] hi_q, lo_q;
    logic          sel;

    assign sel = (op_core == CW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        halt_q <= (i != 0);
        hi_q   <= '1;
        lo_q   <= '1;
      end else if (sel) begin
        if (op == OP_VEC_HI)   hi_q   <= '0;
        if (op == OP_VEC_LO)   lo_q   <= op_addr;
        if (op == OP_HALT_CLR) halt_q <= 1'b0;
        if (op == OP_HALT_SET) halt_q <= 1'b1;
      end
    end

    assign halt[i]           = halt_q;
    assign vec_hi[i*AW +: AW] = hi_q;
    assign vec_lo[i*AW +: AW] = lo_q;
  end
endmodule

// File: rtl/pzone_seq.sv
module pzone_seq
  import pzs_pkg::*;
#(
  parameter int N          = 4,
  parameter int AW         = 32,
  parameter int CYC_PER_MS = 100000,
  parameter int TMO_MS     = 500,
  localparam int CW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_up,
  input  logic [CW-1:0]   cmd_core,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            err_clr,
  input  logic [N-1:0]    zs_mem_ok,
  input  logic [N-1:0]    zs_pg_ok,
  input  logic [N-1:0]    zs_off,
  output logic [N-1:0]    zc_clk_en,
  output logic [N-1:0]    zc_rst_rel,
  output logic [N-1:0]    zc_mem_pwr,
  output logic [N-1:0]    zc_aux_pwr,
  output logic [N-1:0]    zc_iso,
  output logic [N-1:0]    zc_manual,
  output logic [N-1:0]    halt,
  output logic [N*AW-1:0] vec_hi,
  output logic [N*AW-1:0] vec_lo,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            tmo_err
);
  localparam int LIM = CYC_PER_MS * TMO_MS;

  pzs_op_e       op;
  logic [CW-1:0] op_core;
  logic [AW-1:0] op_addr;
  logic          wait_run, wait_met, expire;

  pzs_fsm #(.N(N), .CW(CW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_up(cmd_up),
    .cmd_core(cmd_core), .cmd_addr(cmd_addr), .err_clr(err_clr),
    .mem_ok(zs_mem_ok), .pg_ok(zs_pg_ok), .off_st(zs_off),
    .expire(expire), .wait_run(wait_run), .wait_met(wait_met),
    .op(op), .op_core(op_core), .op_addr(op_addr),
    .busy(busy), .done(done), .fail(fail), .tmo_err(tmo_err)
  );

  pzs_timer #(.LIM(LIM)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .met(wait_met), .expire(expire)
  );

  pzs_zone_bank #(.N(N), .CW(CW)) u_zones (
    .clk(clk), .rst_n(rst_n), .op(op), .op_core(op_core),
    .clk_en(zc_clk_en), .rst_rel(zc_rst_rel), .mem_pwr(zc_mem_pwr),
    .aux_pwr(zc_aux_pwr), .iso(zc_iso), .manual(zc_manual)
  );

  pzs_boot_bank #(.N(N), .CW(CW), .AW(AW)) u_boot (
    .clk(clk), .rst_n(rst_n), .op(op), .op_core(op_core), .op_addr(op_addr),
    .halt(halt), .vec_hi(vec_hi), .vec_lo(vec_lo)
  );
endmodule

// File: rtl/pzs_chk.sv
module pzs_chk #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_up,
  input logic [CW-1:0] cmd_core,
  input logic          err_clr,
  input logic [N-1:0]  zc_clk_en,
  input logic [N-1:0]  zc_rst_rel,
  input logic [N-1:0]  zc_mem_pwr,
  input logic [N-1:0]  zc_iso,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          tmo_err
);
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_up || cmd_core != '0)) |=> busy);

  a_r8_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_up && cmd_core == '0) |=>
      (fail && !busy && $stable(zc_rst_rel) && $stable(zc_iso) && $stable(zc_clk_en)));

  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !err_clr) |=> tmo_err);

  a_r7_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> !cmd_ready);

  a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> (!done && !busy));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_one_zone: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0((zc_clk_en ^ $past(zc_clk_en)) | (zc_iso ^ $past(zc_iso)) |
             (zc_mem_pwr ^ $past(zc_mem_pwr)) | (zc_rst_rel ^ $past(zc_rst_rel))));
endmodule

bind pzone_seq pzs_chk #(.N(N), .CW(CW)) u_pzs_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_up(cmd_up), .cmd_core(cmd_core), .err_clr(err_clr),
  .zc_clk_en(zc_clk_en), .zc_rst_rel(zc_rst_rel), .zc_mem_pwr(zc_mem_pwr),
  .zc_iso(zc_iso), .busy(busy), .done(done), .fail(fail), .tmo_err(tmo_err)
);

// File: tb/test_pzone_seq.sv
module test_pzone_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int CPM = 4;
  localparam int TMS = 500;
  localparam int LIM = CPM * TMS;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, err_clr = 1'b0;
  logic [CW-1:0] cmd_core = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [N-1:0] mem_ok = '0, pg_ok = '0, off_st = '1, frz = '0;
  logic cmd_ready, busy, done, fail, tmo_err;
  logic [N-1:0] zc_clk_en, zc_rst_rel, zc_mem_pwr, zc_aux_pwr, zc_iso, zc_manual, halt;
  logic [N*AW-1:0] vec_hi, vec_lo;

  int errors = 0, checks = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pzone_seq #(.N(N), .AW(AW), .CYC_PER_MS(CPM), .TMO_MS(TMS)) i_pzone_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_up(cmd_up), .cmd_core(cmd_core), .cmd_addr(cmd_addr), .err_clr(err_clr),
    .zs_mem_ok(mem_ok), .zs_pg_ok(pg_ok), .zs_off(off_st),
    .zc_clk_en(zc_clk_en), .zc_rst_rel(zc_rst_rel), .zc_mem_pwr(zc_mem_pwr),
    .zc_aux_pwr(zc_aux_pwr), .zc_iso(zc_iso), .zc_manual(zc_manual),
    .halt(halt), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .busy(busy), .done(done), .fail(fail), .tmo_err(tmo_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Plant: power lines answer after a few cycles unless frozen.
  int pm[N], pp[N];
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!frz[i]) begin
        if (mem_ok[i] != zc_mem_pwr[i]) begin
          pm[i]++;
          if (pm[i] >= 3) begin mem_ok[i] = zc_mem_pwr[i]; pm[i] = 0; end
        end else pm[i] = 0;
      end
      if (pg_ok[i] != (zc_aux_pwr[i] & zc_mem_pwr[i])) begin
        pp[i]++;
        if (pp[i] >= 2) begin pg_ok[i] = zc_aux_pwr[i] & zc_mem_pwr[i]; pp[i] = 0; end
      end else pp[i] = 0;
      if (zc_rst_rel[i] !== 1'bx) off_st[i] = !zc_rst_rel[i];
    end
  end

  // Behavioural reference: a list of pending steps, one consumed per clock.
  logic [N-1:0] m_clk, m_rst, m_mem, m_aux, m_iso, m_man, m_halt;
  logic [AW-1:0] m_hi[N], m_lo[N];
  bit m_err, m_done, m_fail, m_up;
  int q[$];
  int m_core, m_cnt;
  logic [AW-1:0] m_addr;

  task automatic m_apply(input int o);
    case (o)
      1: m_iso[m_core] = 1;   2: m_iso[m_core] = 0;   3: m_man[m_core] = 1;
      4: m_aux[m_core] = 1;   5: m_aux[m_core] = 0;   6: m_mem[m_core] = 1;
      7: m_mem[m_core] = 0;   8: m_clk[m_core] = 1;   9: m_clk[m_core] = 0;
      10: m_rst[m_core] = 1;  11: m_rst[m_core] = 0;  12: m_hi[m_core] = '0;
      13: m_lo[m_core] = m_addr; 14: m_halt[m_core] = 0; 15: m_halt[m_core] = 1;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit rdy;
    m_done = 0; m_fail = 0;
    if (!rst_n) begin
      {m_clk, m_rst, m_mem, m_aux, m_iso, m_man} = '0;
      m_halt = '1; m_halt[0] = 0;
      for (int i = 0; i < N; i++) begin m_hi[i] = '1; m_lo[i] = '1; end
      m_err = 0; q.delete(); m_cnt = 0;
    end else begin
      rdy = (q.size() == 0) && !m_err;
      if (err_clr) m_err = 0;
      if (q.size() == 0) begin
        if (cmd_valid && rdy) begin
          m_core = int'(cmd_core); m_addr = cmd_addr; m_up = cmd_up;
          if (!cmd_up && cmd_core == 0) m_fail = 1;
          else if (cmd_up) begin
            if (off_st[m_core]) q = {1, 3, 4, 6, 100, 8, 101, 2, 10};
            q = {q, 12, 13, 14};
          end else q = {3, 11, 9, 1, 7, 100, 5, 101, 15};
        end
      end else if (q[0] >= 100) begin
        if (((q[0] == 100) ? mem_ok[m_core] : pg_ok[m_core]) == m_up) begin
          void'(q.pop_front()); m_cnt = 0;
        end else if (m_cnt == LIM - 1) begin
          m_err = 1; q.delete(); m_cnt = 0;
        end else m_cnt++;
      end else begin
        m_apply(q[0]); void'(q.pop_front());
        if (q.size() == 0) m_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({zc_clk_en, zc_rst_rel, zc_mem_pwr, zc_aux_pwr, zc_iso, zc_manual} ===
          {m_clk, m_rst, m_mem, m_aux, m_iso, m_man}, "R3/R4 zone lines",
          {zc_clk_en, zc_rst_rel, zc_mem_pwr, zc_aux_pwr, zc_iso, zc_manual},
          {m_clk, m_rst, m_mem, m_aux, m_iso, m_man});
      for (int i = 0; i < N; i++)
        chk(vec_hi[i*AW +: AW] === m_hi[i] && vec_lo[i*AW +: AW] === m_lo[i] && halt[i] === m_halt[i],
            "R10/R11 boot words and halt", {halt[i], vec_hi[i*AW +: AW], vec_lo[i*AW +: AW]},
            {m_halt[i], m_hi[i], m_lo[i]});
      chk(cmd_ready === ((q.size() == 0) && !m_err) && busy === (q.size() != 0), "R2 handshake",
          {cmd_ready, busy}, {((q.size() == 0) && !m_err), (q.size() != 0)});
      chk({done, fail, tmo_err} === {m_done, m_fail, m_err}, "R6/R8 flags",
          {done, fail, tmo_err}, {m_done, m_fail, m_err});
    end
  end

  task automatic send(input bit up, input int core, input logic [AW-1:0] addr);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_up = up; cmd_core = CW'(core); cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    bit seen_done;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    chk({zc_clk_en, zc_rst_rel, zc_mem_pwr, zc_aux_pwr, zc_iso, zc_manual} == '0, "R1 zone lines", zc_iso, 0);
    chk(halt == 4'b1110, "R1 halt", halt, 4'b1110);
    chk(vec_hi == '1 && vec_lo == '1, "R1 boot words", vec_lo[AW-1:0], 16'hffff);
    chk(cmd_ready && !busy && !done && !fail && !tmo_err, "R1 flags", {cmd_ready, busy, tmo_err}, 3'b100);

    // R3, R10: full power-up of core 1
    send(1, 1, 16'h1234);
    chk(busy && !cmd_ready, "R2 busy after accept", {busy, cmd_ready}, 2'b10);
    wait_done(n);
    chk(done, "R10 done pulse", done, 1);
    chk(halt == 4'b1100, "R10 only core 1 released", halt, 4'b1100);
    chk(vec_hi[AW +: AW] == 0 && vec_lo[AW +: AW] == 16'h1234, "R10 boot words",
        vec_lo[AW +: AW], 16'h1234);
    chk(zc_rst_rel[1] && zc_clk_en[1] && !zc_iso[1] && zc_mem_pwr[1], "R3 zone on",
        {zc_rst_rel[1], zc_clk_en[1], zc_iso[1]}, 3'b110);

    // R9: zone already on -> boot only
    send(1, 1, 16'h00c0);
    wait_done(n);
    chk(n == 3, "R9 boot-only length", n, 3);
    chk(vec_lo[AW +: AW] == 16'h00c0, "R9 address reloaded", vec_lo[AW +: AW], 16'h00c0);

    // R8: core 0 may not power down
    send(0, 0, 0);
    chk(fail && !busy, "R8 refused", {fail, busy}, 2'b10);
    @(negedge clk);
    chk(!fail && zc_manual[0] == 0 && halt[0] == 0, "R8 no change", {fail, zc_manual[0], halt[0]}, 0);

    // R4, R11: power down core 1
    send(0, 1, 0);
    wait_done(n);
    chk(halt == 4'b1110, "R11 halt set", halt, 4'b1110);
    chk(!zc_clk_en[1] && !zc_rst_rel[1] && zc_iso[1] && !zc_mem_pwr[1] && !zc_aux_pwr[1],
        "R4 zone off", {zc_clk_en[1], zc_rst_rel[1], zc_iso[1], zc_mem_pwr[1]}, 4'b0010);

    // R5: wait step advances on the edge after the status arrives
    frz[3] = 1;
    send(1, 3, 16'h0300);
    repeat (20) @(negedge clk);
    chk(busy && !zc_clk_en[3], "R5 holds while low", {busy, zc_clk_en[3]}, 2'b10);
    mem_ok[3] = 1;
    @(negedge clk);
    chk(!zc_clk_en[3], "R5 no same-cycle step", zc_clk_en[3], 0);
    @(negedge clk);
    chk(zc_clk_en[3], "R5 step after wait", zc_clk_en[3], 1);
    frz[3] = 0;
    wait_done(n);

    // R6, R7: timeout on core 2
    frz[2] = 1; mem_ok[2] = 0;
    send(1, 2, 16'h0200);
    seen_done = 0; n = 0;
    while (!tmo_err && n < LIM + 100) begin
      @(negedge clk); n++;
      if (done) seen_done = 1;
    end
    chk(tmo_err && !seen_done && !busy, "R6 timeout", {tmo_err, seen_done, busy}, 3'b100);
    chk(zc_mem_pwr[2] && !zc_clk_en[2], "R6 outputs held", {zc_mem_pwr[2], zc_clk_en[2]}, 2'b10);
    cmd_valid = 1; cmd_up = 1; cmd_core = 1;
    repeat (3) @(negedge clk);
    chk(!cmd_ready && !busy && tmo_err, "R7 blocked while error", {cmd_ready, busy}, 0);
    cmd_valid = 0;
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(!tmo_err && cmd_ready, "R7 cleared", {tmo_err, cmd_ready}, 2'b01);

    // R12: core 0 never touched
    chk({zc_clk_en[0], zc_rst_rel[0], zc_mem_pwr[0], zc_aux_pwr[0], zc_iso[0], zc_manual[0]} == 0
        && halt[0] == 0, "R12 core 0 untouched", zc_manual, 0);

    frz[2] = 0;
    send(1, 2, 16'h0222);
    wait_done(n);
    chk(halt[2] == 0 && vec_lo[2*AW +: AW] == 16'h0222, "R10 core 2 released",
        vec_lo[2*AW +: AW], 16'h0222);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule